// File: doc/BRIEF.md
# Speculation Shadow Matrix

This block sits beside an out-of-order scoreboard and stops issued function units from writing their results while the outcome of an earlier speculative condition is still unknown. Each speculative condition has its own shadow source. An outstanding branch, an instruction that may raise an exception and a pending predicate mask are each a separate source, so two nested branches use two sources. When a source is armed, it begins to collect every function unit issued while it stays active. That set of units is the source's row of the matrix.

A source later resolves. Success releases its hold on the units in its row. Failure sends a kill pulse to every unit in the row, in the same cycle, so that the unit and its computation pipeline discard the instruction. A unit becomes writeable only when no active source still covers it. A global cancel, used for a speculation fence and on exceptions, fails every active source at once. A writeable unit returns to idle when it reports that its write is done.

Top module: `shadow_matrix`

## Requirements
- R1: Reset leaves every source inactive and every unit idle, with `kill_o` and `wr_en_o` all zero.
- R2: `arm_i[s]` activates an inactive source from the next cycle with an empty row. An arm on an active source is ignored and leaves its row intact. An arm in a cycle with `cancel_i` high is ignored.
- R3: An issue to an idle unit makes it busy. The unit joins the row of every source that was active before that cycle and is not resolving in it. An issue in the same cycle as an arm is not captured by that source. An issue to a busy unit is ignored.
- R4: `wr_en_o[u]` is 1 exactly when unit u is busy and no active source holds it. A unit issued with no active source is writeable in the next cycle.
- R5: `ok_i[s]` on an active source deactivates it and empties its row. From the next cycle, units that it alone held are writeable.
- R6: `fail_i[s]` on an active source drives `kill_o` high, in that same cycle, for every unit in its row. Those units are idle in the next cycle, and their bits are removed from every other row.
- R7: Failure beats success. With both asserted on one source, that source kills. A unit killed by one source while another source covering it succeeds does not become writeable.
- R8: `cancel_i` fails every active source in one cycle, with the kills of R6.
- R9: `ok_i` and `fail_i` on an inactive source have no effect. No kill is produced while no source is active.
- R10: `done_i[u]` on a writeable unit returns it to idle. On a unit that is held or idle, `done_i` is ignored.
- R11: `kill_o[u]` and `wr_en_o[u]` are never both high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | NSRC | Per-source arm request |
| ok_i | input | NSRC | Per-source success |
| fail_i | input | NSRC | Per-source failure |
| cancel_i | input | 1 | Fail all active sources |
| issue_i | input | NFU | Per-unit issue |
| done_i | input | NFU | Per-unit write completed |
| kill_o | output | NFU | Per-unit kill (go die), combinational |
| wr_en_o | output | NFU | Per-unit writeable |

## Verification
The critical collision is a success and a failure landing in the same cycle on one unit. This can happen from two different sources, or from both inputs of one source. The bench provokes it with a sweep over every set of covering sources and every split of those sources into success and failure, all resolved in a single cycle. For each case it computes the expected kill as the OR of the covering sources that fail. It expects the unit to be writeable afterwards only when none of its covering sources failed.

// File: rtl/shadow_pkg.sv
`timescale 1ns/1ps
package shadow_pkg;
    typedef enum logic {
        FU_IDLE = 1'b0,
        FU_BUSY = 1'b1
    } fu_state_e;
endpackage

// File: rtl/shadow_row.sv
`timescale 1ns/1ps
module shadow_row #(
    parameter int NFU = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm_i,
    input  logic           ok_i,
    input  logic           fail_i,
    input  logic           cancel_i,
    input  logic [NFU-1:0] capture_i,
    input  logic [NFU-1:0] kill_all_i,
    output logic           active_o,
    output logic [NFU-1:0] mask_o,
    output logic [NFU-1:0] kill_o
);
    typedef struct packed {
        logic           active;
        logic [NFU-1:0] mask;
    } row_t;

    row_t row_d, row_q;
    logic fail_eff, ok_eff;

    always_comb begin
        row_d    = row_q;
        fail_eff = row_q.active & (fail_i | cancel_i);
        ok_eff   = row_q.active & ok_i & ~fail_eff;
        kill_o   = fail_eff ? row_q.mask : '0;
        if (row_q.active) begin
            if (fail_eff || ok_eff) begin
                row_d.active = 1'b0;
                row_d.mask   = '0;
            end else begin
                row_d.mask = (row_q.mask | capture_i) & ~kill_all_i;
            end
        end else if (arm_i && !cancel_i) begin
            row_d.active = 1'b1;
            row_d.mask   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign active_o = row_q.active;
    assign mask_o   = row_q.mask;
endmodule

// File: rtl/shadow_fu.sv
`timescale 1ns/1ps
module shadow_fu
    import shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic kill_i,
    input  logic done_i,
    input  logic held_i,
    output logic accept_o,
    output logic busy_o,
    output logic wr_en_o
);
    typedef struct packed {
        fu_state_e st;
    } fu_t;

    fu_t fu_d, fu_q;

    always_comb begin
        fu_d     = fu_q;
        accept_o = (fu_q.st == FU_IDLE) & issue_i;
        wr_en_o  = (fu_q.st == FU_BUSY) & ~held_i;
        unique case (fu_q.st)
            FU_IDLE: if (issue_i) fu_d.st = FU_BUSY;
            FU_BUSY: begin
                if (kill_i) begin
                    fu_d.st = FU_IDLE;
                end else if (done_i && !held_i) begin
                    fu_d.st = FU_IDLE;
                end
            end
            default: fu_d.st = FU_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fu_q.st <= FU_IDLE;
        end else begin
            fu_q <= fu_d;
        end
    end

    assign busy_o = (fu_q.st == FU_BUSY);
endmodule

// File: rtl/shadow_matrix.sv
`timescale 1ns/1ps
module shadow_matrix #(
    parameter int NSRC = 4,
    parameter int NFU  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] arm_i,
    input  logic [NSRC-1:0] ok_i,
    input  logic [NSRC-1:0] fail_i,
    input  logic            cancel_i,
    input  logic [NFU-1:0]  issue_i,
    input  logic [NFU-1:0]  done_i,
    output logic [NFU-1:0]  kill_o,
    output logic [NFU-1:0]  wr_en_o
);
    logic [NSRC-1:0][NFU-1:0] row_mask;
    logic [NSRC-1:0][NFU-1:0] row_kill;
    logic [NSRC-1:0]          src_active;
    logic [NFU-1:0]           kill_vec;
    logic [NFU-1:0]           held_vec;
    logic [NFU-1:0]           accept_vec;
    logic [NFU-1:0]           fu_busy;

    for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
        shadow_row #(.NFU(NFU)) u_row (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm_i      (arm_i[gs]),
            .ok_i       (ok_i[gs]),
            .fail_i     (fail_i[gs]),
            .cancel_i   (cancel_i),
            .capture_i  (accept_vec),
            .kill_all_i (kill_vec),
            .active_o   (src_active[gs]),
            .mask_o     (row_mask[gs]),
            .kill_o     (row_kill[gs])
        );
    end

    always_comb begin
        kill_vec = '0;
        held_vec = '0;
        for (int s = 0; s < NSRC; s++) begin
            kill_vec = kill_vec | row_kill[s];
            held_vec = held_vec | row_mask[s];
        end
    end

    for (genvar gu = 0; gu < NFU; gu++) begin : g_fu
        shadow_fu u_fu (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_i  (issue_i[gu]),
            .kill_i   (kill_vec[gu]),
            .done_i   (done_i[gu]),
            .held_i   (held_vec[gu]),
            .accept_o (accept_vec[gu]),
            .busy_o   (fu_busy[gu]),
            .wr_en_o  (wr_en_o[gu])
        );
    end

    assign kill_o = kill_vec;
endmodule

// File: rtl/shadow_matrix_chk.sv
`timescale 1ns/1ps
module shadow_matrix_chk #(
    parameter int NSRC = 4,
    parameter int NFU  = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] ok_i,
    input logic [NSRC-1:0] fail_i,
    input logic            cancel_i,
    input logic [NSRC-1:0] src_active,
    input logic [NFU-1:0]  fu_busy,
    input logic [NFU-1:0]  kill_o,
    input logic [NFU-1:0]  wr_en_o
);
    a_r11_no_write_and_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o & kill_o) == '0);

    a_r6_killed_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_o != '0) |=> ((fu_busy & $past(kill_o)) == '0));

    a_r6_kill_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_o & ~fu_busy) == '0);

    a_r8_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_i |=> (src_active == '0));

    a_r5_resolve_deactivates: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_active & (ok_i | fail_i)) != '0) |=>
            ((src_active & $past(src_active & (ok_i | fail_i))) == '0));

    a_r9_no_kill_when_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (src_active == '0) |-> (kill_o == '0));
endmodule

bind shadow_matrix shadow_matrix_chk #(.NSRC(NSRC), .NFU(NFU)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ok_i       (ok_i),
    .fail_i     (fail_i),
    .cancel_i   (cancel_i),
    .src_active (src_active),
    .fu_busy    (fu_busy),
    .kill_o     (kill_o),
    .wr_en_o    (wr_en_o)
);

// File: tb/sim_shadow_matrix.sv
`timescale 1ns/1ps
module sim_shadow_matrix;
    localparam int NS = 3;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] arm_i = '0, ok_i = '0, fail_i = '0;
    logic          cancel_i = 1'b0;
    logic [NF-1:0] issue_i = '0, done_i = '0;
    logic [NF-1:0] kill_o, wr_en_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shadow_matrix #(.NSRC(NS), .NFU(NF)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ok_i(ok_i), .fail_i(fail_i),
        .cancel_i(cancel_i), .issue_i(issue_i), .done_i(done_i),
        .kill_o(kill_o), .wr_en_o(wr_en_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic cleanup;
        cancel_i = 1'b1;
        tick();
        cancel_i = 1'b0;
        done_i = '1;
        tick();
        done_i = '0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 kill after reset", 32'(kill_o), 32'h0);
        chk("R1 wr_en after reset", 32'(wr_en_o), 32'h0);
        rst_n = 1'b1;
        tick();

        // R4/R10: unshadowed issue, then release
        issue_i = 4'b0001; tick(); issue_i = '0;
        chk("R4 unshadowed writeable", 32'(wr_en_o), 32'h1);
        done_i = 4'b0001; tick(); done_i = '0;
        chk("R10 done releases", 32'(wr_en_o), 32'h0);

        // Sweep: covering set S, failing subset F, resolved in one cycle (R5 R6 R7 R9)
        for (int s = 0; s < 8; s++) begin
            for (int f = 0; f < 8; f++) begin
                arm_i = 3'(s); tick(); arm_i = '0;
                issue_i = 4'b0001; tick(); issue_i = '0;
                chk("R3 R4 held before resolve", 32'(wr_en_o), (s == 0) ? 32'h1 : 32'h0);
                ok_i = ~3'(f); fail_i = 3'(f);
                #1;
                chk("R6 R7 R9 kill on fail", 32'(kill_o), ((s & f) != 0) ? 32'h1 : 32'h0);
                tick(); ok_i = '0; fail_i = '0;
                chk("R5 R7 writeable after resolve", 32'(wr_en_o), ((s & f) == 0) ? 32'h1 : 32'h0);
                done_i = '1; tick(); done_i = '0;
                chk("R10 idle after done", 32'(wr_en_o), 32'h0);
            end
        end

        // R3: issue in same cycle as arm not captured
        arm_i = 3'b001; issue_i = 4'b0001; tick(); arm_i = '0; issue_i = '0;
        chk("R3 same-cycle arm not captured", 32'(wr_en_o), 32'h1);
        fail_i = 3'b001; #1;
        chk("R3 no kill for uncaptured", 32'(kill_o), 32'h0);
        tick(); fail_i = '0;
        chk("R3 uncaptured stays writeable", 32'(wr_en_o), 32'h1);
        cleanup();

        // R3: issue to busy unit ignored
        issue_i = 4'b0010; tick(); issue_i = '0;
        arm_i = 3'b001; tick(); arm_i = '0;
        issue_i = 4'b0010; tick(); issue_i = '0;
        fail_i = 3'b001; #1;
        chk("R3 busy reissue not captured", 32'(kill_o), 32'h0);
        tick(); fail_i = '0;
        chk("R3 busy unit still writeable", 32'(wr_en_o), 32'h2);
        cleanup();

        // R10: done on held unit ignored
        arm_i = 3'b001; tick(); arm_i = '0;
        issue_i = 4'b0100; tick(); issue_i = '0;
        done_i = 4'b0100; tick(); done_i = '0;
        chk("R10 held unit not writeable", 32'(wr_en_o), 32'h0);
        ok_i = 3'b001; tick(); ok_i = '0;
        chk("R10 done while held ignored", 32'(wr_en_o), 32'h4);
        done_i = 4'b0100; tick(); done_i = '0;
        chk("R10 done releases writeable", 32'(wr_en_o), 32'h0);

        // R2/R5: nested sources, re-arm of active source ignored
        arm_i = 3'b001; tick(); arm_i = '0;
        issue_i = 4'b0001; tick(); issue_i = '0;
        arm_i = 3'b010; tick(); arm_i = '0;
        issue_i = 4'b0010; tick(); issue_i = '0;
        chk("R4 nested both held", 32'(wr_en_o), 32'h0);
        ok_i = 3'b010; tick(); ok_i = '0;
        chk("R5 inner success keeps outer hold", 32'(wr_en_o), 32'h0);
        arm_i = 3'b001; tick(); arm_i = '0;
        chk("R2 re-arm of active ignored", 32'(wr_en_o), 32'h0);
        ok_i = 3'b001; tick(); ok_i = '0;
        chk("R5 outer success releases both", 32'(wr_en_o), 32'h3);
        cleanup();

        // R6: killed bits removed from other rows
        arm_i = 3'b011; tick(); arm_i = '0;
        issue_i = 4'b0001; tick(); issue_i = '0;
        fail_i = 3'b001; #1;
        chk("R6 kill from first source", 32'(kill_o), 32'h1);
        tick(); fail_i = '0;
        chk("R6 killed unit idle", 32'(wr_en_o), 32'h0);
        fail_i = 3'b010; #1;
        chk("R6 bit cleared in other row", 32'(kill_o), 32'h0);
        tick(); fail_i = '0;
        cleanup();

        // R7: ok and fail on the same source
        arm_i = 3'b001; tick(); arm_i = '0;
        issue_i = 4'b1000; tick(); issue_i = '0;
        ok_i = 3'b001; fail_i = 3'b001; #1;
        chk("R7 fail wins on one source", 32'(kill_o), 32'h8);
        tick(); ok_i = '0; fail_i = '0;
        chk("R7 not writeable after fail", 32'(wr_en_o), 32'h0);
        cleanup();

        // R8/R2: cancel fails all, arm with cancel ignored
        arm_i = 3'b011; tick(); arm_i = '0;
        issue_i = 4'b0011; tick(); issue_i = '0;
        cancel_i = 1'b1; arm_i = 3'b100; #1;
        chk("R8 cancel kills shadowed units", 32'(kill_o), 32'h3);
        tick(); cancel_i = 1'b0; arm_i = '0;
        chk("R8 killed units idle", 32'(wr_en_o), 32'h0);
        issue_i = 4'b0100; tick(); issue_i = '0;
        chk("R2 arm during cancel ignored", 32'(wr_en_o), 32'h4);
        cleanup();

        // R3: issue during resolving success not captured
        arm_i = 3'b001; tick(); arm_i = '0;
        issue_i = 4'b0001; ok_i = 3'b001; tick(); issue_i = '0; ok_i = '0;
        chk("R3 resolving source does not capture", 32'(wr_en_o), 32'h1);
        cleanup();

        // R9: resolve inputs with nothing active
        ok_i = 3'b011; fail_i = 3'b110; #1;
        chk("R9 no kill when inactive", 32'(kill_o), 32'h0);
        tick(); ok_i = '0; fail_i = '0;
        chk("R9 no writeable units", 32'(wr_en_o), 32'h0);

        report();
    end
endmodule